// File: doc/BRIEF.md
# RISC Instruction Field Decoder

This block turns one 32-bit instruction word into the values an execution stage needs. These are the register indices, a fully extended immediate, an operation class and the control flags for arithmetic, shift, branch, call, jump-and-link, state-register write and memory access instructions. The word is sampled on each clock edge, and the decoded result is held in a single output register, so it is available one cycle after the word is presented.

The decoder also handles the destination register being zero. Ordinary arithmetic becomes a no-op. Compare-subtract, window save and jump-and-link keep their class and send the result to a scratch destination. A load to register zero still performs its access and discards the data. Memory instructions carry a packed five-bit variant index that a downstream dispatch table can use directly. Any encoding outside the supported set raises the illegal flag. So does a 64-bit shift while the 32-bit mode input is high.

Top module: `isa_field_decoder`

## Requirements
- R1: `rs1_o` = word bits 18:14, `rs2_o` = bits 4:0, `use_imm_o` = bit 13, and `rd_o` = bits 29:25 (except for call, R5). These hold for every word, illegal ones included.
- R2: Outputs show the decode of the word and mode sampled at the previous rising clock edge. While `rst_ni` is low, every output is zero. Class codes: 0 no-op, 1 upper-immediate set, 2 branch, 3 call, 4 ALU, 5 jump-and-link, 6 load/store, 7 state write, 8 illegal.
- R3: Major opcode (bits 31:30) 0 with bits 24:22 = 4 is class 1. Its `imm_o` is bits 21:0 shifted left by 10 and zero-extended, and `write_rd_o` = 1.
- R4: Major 0 with bits 24:22 = 2 and rd = 8 is class 2. Its `imm_o` is bits 21:0 sign-extended and multiplied by 4. Any other rd with this minor code is illegal.
- R5: Major 1 is class 3. Its `imm_o` is {bits 29:0, 2'b00} sign-extended from bit 31, `rd_o` = 15 and `write_rd_o` = 1.
- R6: For major 2, the minor code is bits 24:19. Codes 0,1,2,3,4,20 and 60 are class 4 with `alu_op_o` 0 add, 1 and, 2 or, 3 xor, 4 sub, 5 compare-subtract and 9 save. Their `imm_o` is bits 12:0 sign-extended.
- R7: Minor codes 37, 38 and 39 are class 4 with `alu_op_o` 6 left shift, 7 logical right shift and 8 arithmetic right shift. `wide_shift_o` = bit 12. `imm_o` is bits 5:0 when bit 12 is set and bits 4:0 otherwise. A wide shift while `mode32_i` is high is illegal.
- R8: For any class 4 instruction with rd = 0, compare-subtract and save keep class 4 and set `scratch_dst_o`. Every other class 4 instruction becomes class 0 with `alu_op_o` 0 and `wide_shift_o` 0. Class 1 with rd = 0 becomes class 0. `write_rd_o` is 0 in all these cases.
- R9: Minor code 56 is class 5 with `imm_o` equal to the sign-extended 13-bit field. With rd = 0 it sets `scratch_dst_o`; otherwise it sets `write_rd_o`.
- R10: Major 3 minor codes decode as follows, with size 0 byte, 1 half, 2 word, 3 doubleword.
  - Unsigned loads: 0 word, 1 byte, 2 half.
  - Signed loads: 8 word, 9 byte, 10 half.
  - Doubleword load: 11.
  - Stores: 4 word, 5 byte, 6 half, 14 doubleword.

  All of these are class 6 with `imm_o` equal to the sign-extended 13-bit field. Other minor codes are illegal.
- R11: `ls_index_o` = use_imm*16 + store*8 + size*2 + signed for class 6, and is 0 for every other class.
- R12: A load with rd = 0 stays class 6, sets `discard_o` and clears `write_rd_o`. Stores never set `write_rd_o`.
- R13: Minor code 48 with rd in {0, 6, 23} and minor code 50 with rd in {4, 6, 8} are class 7 with `alu_op_o` 3 and `write_rd_o` 0. Other rd values with these codes are illegal.
- R14: An illegal word sets `illegal_o` and produces class 8. In that case `alu_op_o`, `imm_o` and every control and load/store output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 32 | Instruction word |
| mode32_i | input | 1 | 32-bit mode; forbids wide shifts |
| class_o | output | 4 | Operation class |
| alu_op_o | output | 4 | Arithmetic or shift operation |
| rd_o | output | 5 | Destination index |
| rs1_o | output | 5 | First source index |
| rs2_o | output | 5 | Second source index |
| use_imm_o | output | 1 | Immediate selects second operand |
| imm_o | output | XLEN | Extended immediate or displacement |
| wide_shift_o | output | 1 | Shift uses 64-bit form |
| write_rd_o | output | 1 | Result written to register file |
| scratch_dst_o | output | 1 | Result goes to scratch destination |
| discard_o | output | 1 | Load performed, data dropped |
| ls_store_o | output | 1 | Memory access is a store |
| ls_size_o | output | 2 | Access size code |
| ls_signed_o | output | 1 | Load is sign-extended |
| ls_index_o | output | 5 | Packed memory variant index |
| illegal_o | output | 1 | Unsupported encoding |

## Verification
Each output is a pure function of the word registered one edge earlier, so any wrong decode shows at the ports in the very next cycle. The most telling symptoms are a register write to index zero, a scratch flag together with a write, or a nonzero immediate on an illegal word. The bench runs a reference model alongside the design and compares every field group on every cycle. It combines directed corner words (rd zero, mode-restricted shifts, unsupported rd values for branch and state writes) with several hundred pseudo-random words biased toward the supported minor codes.

// File: rtl/isa_dec_pkg.sv
package isa_dec_pkg;

  typedef enum logic [3:0] {
    CL_NOP    = 4'd0,
    CL_SETHI  = 4'd1,
    CL_BRANCH = 4'd2,
    CL_CALL   = 4'd3,
    CL_ALU    = 4'd4,
    CL_JMPL   = 4'd5,
    CL_LDST   = 4'd6,
    CL_SPWR   = 4'd7,
    CL_ILL    = 4'd8
  } iclass_e;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_AND   = 4'd1,
    OP_OR    = 4'd2,
    OP_XOR   = 4'd3,
    OP_SUB   = 4'd4,
    OP_SUBCC = 4'd5,
    OP_SLL   = 4'd6,
    OP_SRL   = 4'd7,
    OP_SRA   = 4'd8,
    OP_SAVE  = 4'd9
  } aluop_e;

  localparam logic [4:0] LINK_REG = 5'd15;
  localparam logic [4:0] BR_ALWAYS = 5'd8;

  typedef struct packed {
    iclass_e    cls;
    aluop_e     op;
    logic [4:0] rd;
    logic [4:0] rs1;
    logic [4:0] rs2;
    logic       use_imm;
    logic       wide;
    logic       write_rd;
    logic       scratch;
    logic       discard;
    logic       ls_store;
    logic [1:0] ls_size;
    logic       ls_signed;
    logic [4:0] ls_index;
    logic       illegal;
  } dec_t;

endpackage

// File: rtl/isa_dec_fields.sv
module isa_dec_fields #(
  parameter int unsigned XLEN = 64
) (
  input  logic [31:0]     instr_i,
  output logic [1:0]      major_o,
  output logic [2:0]      minor_fmt0_o,
  output logic [5:0]      minor_o,
  output logic [4:0]      rd_o,
  output logic [4:0]      rs1_o,
  output logic [4:0]      rs2_o,
  output logic            use_imm_o,
  output logic [XLEN-1:0] simm_o,
  output logic [XLEN-1:0] upper_o,
  output logic [XLEN-1:0] br_disp_o,
  output logic [XLEN-1:0] call_disp_o
);
  localparam int unsigned SIMM_W = 13;
  localparam int unsigned BR_W   = 22;

  assign major_o      = instr_i[31:30];
  assign rd_o         = instr_i[29:25];
  assign minor_fmt0_o = instr_i[24:22];
  assign minor_o      = instr_i[24:19];
  assign rs1_o        = instr_i[18:14];
  assign use_imm_o    = instr_i[13];
  assign rs2_o        = instr_i[4:0];

  assign simm_o      = {{(XLEN-SIMM_W){instr_i[SIMM_W-1]}}, instr_i[SIMM_W-1:0]};
  assign upper_o     = {{(XLEN-32){1'b0}}, instr_i[BR_W-1:0], 10'b0};
  assign br_disp_o   = {{(XLEN-BR_W-2){instr_i[BR_W-1]}}, instr_i[BR_W-1:0], 2'b00};
  assign call_disp_o = {{(XLEN-32){instr_i[29]}}, instr_i[29:0], 2'b00};
endmodule

// File: rtl/isa_dec_arith.sv
module isa_dec_arith
  import isa_dec_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [5:0]      minor_i,
  input  logic [4:0]      rd_i,
  input  logic            mode32_i,
  input  logic [XLEN-1:0] simm_i,
  output logic            valid_o,
  output iclass_e         cls_o,
  output aluop_e          op_o,
  output logic            wide_o,
  output logic            scratch_o,
  output logic            write_rd_o,
  output logic [XLEN-1:0] imm_o
);
  localparam int unsigned WIDE_BIT = 12;

  logic rd_zero;
  assign rd_zero = (rd_i == '0);

  always_comb begin
    valid_o   = 1'b1;
    cls_o     = CL_ALU;
    op_o      = OP_ADD;
    wide_o    = 1'b0;
    scratch_o = 1'b0;
    imm_o     = simm_i;
    unique case (minor_i)
      6'd0, 6'd1, 6'd2, 6'd3, 6'd4: op_o = aluop_e'({1'b0, minor_i[2:0]});
      6'd20: op_o = OP_SUBCC;
      6'd60: op_o = OP_SAVE;
      6'd37, 6'd38, 6'd39: begin
        op_o   = (minor_i == 6'd37) ? OP_SLL : (minor_i == 6'd38) ? OP_SRL : OP_SRA;
        wide_o = simm_i[WIDE_BIT];
        imm_o  = wide_o ? {{(XLEN-6){1'b0}}, simm_i[5:0]} : {{(XLEN-5){1'b0}}, simm_i[4:0]};
        if (wide_o && mode32_i) valid_o = 1'b0;
      end
      6'd56: cls_o = CL_JMPL;
      6'd48: begin
        cls_o   = CL_SPWR;
        op_o    = OP_XOR;
        valid_o = (rd_i == 5'd0) || (rd_i == 5'd6) || (rd_i == 5'd23);
      end
      6'd50: begin
        cls_o   = CL_SPWR;
        op_o    = OP_XOR;
        valid_o = (rd_i == 5'd4) || (rd_i == 5'd6) || (rd_i == 5'd8);
      end
      default: valid_o = 1'b0;
    endcase
    // destination zero: compare/save/jump keep a scratch target, the rest vanish
    if (rd_zero && cls_o == CL_ALU) begin
      if (op_o == OP_SUBCC || op_o == OP_SAVE) scratch_o = 1'b1;
      else begin
        cls_o  = CL_NOP;
        op_o   = OP_ADD;
        wide_o = 1'b0;
      end
    end
    if (rd_zero && cls_o == CL_JMPL) scratch_o = 1'b1;
    write_rd_o = !rd_zero && (cls_o == CL_ALU || cls_o == CL_JMPL);
  end
endmodule

// File: rtl/isa_dec_mem.sv
module isa_dec_mem (
  input  logic [5:0] minor_i,
  input  logic [4:0] rd_i,
  input  logic       use_imm_i,
  output logic       valid_o,
  output logic       store_o,
  output logic [1:0] size_o,
  output logic       signed_o,
  output logic [4:0] index_o,
  output logic       write_rd_o,
  output logic       discard_o
);
  always_comb begin
    valid_o  = 1'b1;
    store_o  = 1'b0;
    signed_o = 1'b0;
    size_o   = 2'd2;
    unique case (minor_i)
      6'd0:  size_o = 2'd2;
      6'd1:  size_o = 2'd0;
      6'd2:  size_o = 2'd1;
      6'd8:  begin size_o = 2'd2; signed_o = 1'b1; end
      6'd9:  begin size_o = 2'd0; signed_o = 1'b1; end
      6'd10: begin size_o = 2'd1; signed_o = 1'b1; end
      6'd11: size_o = 2'd3;
      6'd4:  begin size_o = 2'd2; store_o = 1'b1; end
      6'd5:  begin size_o = 2'd0; store_o = 1'b1; end
      6'd6:  begin size_o = 2'd1; store_o = 1'b1; end
      6'd14: begin size_o = 2'd3; store_o = 1'b1; end
      default: valid_o = 1'b0;
    endcase
    index_o    = {use_imm_i, store_o, size_o, signed_o};
    write_rd_o = !store_o && (rd_i != '0);
    discard_o  = !store_o && (rd_i == '0);
  end
endmodule

// File: rtl/isa_field_decoder.sv
module isa_field_decoder
  import isa_dec_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [31:0]     instr_i,
  input  logic            mode32_i,
  output logic [3:0]      class_o,
  output logic [3:0]      alu_op_o,
  output logic [4:0]      rd_o,
  output logic [4:0]      rs1_o,
  output logic [4:0]      rs2_o,
  output logic            use_imm_o,
  output logic [XLEN-1:0] imm_o,
  output logic            wide_shift_o,
  output logic            write_rd_o,
  output logic            scratch_dst_o,
  output logic            discard_o,
  output logic            ls_store_o,
  output logic [1:0]      ls_size_o,
  output logic            ls_signed_o,
  output logic [4:0]      ls_index_o,
  output logic            illegal_o
);
  logic [1:0]      major;
  logic [2:0]      minor0;
  logic [5:0]      minor;
  logic [4:0]      f_rd, f_rs1, f_rs2;
  logic            f_imm;
  logic [XLEN-1:0] simm, upper, br_disp, call_disp;

  isa_dec_fields #(.XLEN(XLEN)) u_fields (
    .instr_i(instr_i), .major_o(major), .minor_fmt0_o(minor0), .minor_o(minor),
    .rd_o(f_rd), .rs1_o(f_rs1), .rs2_o(f_rs2), .use_imm_o(f_imm),
    .simm_o(simm), .upper_o(upper), .br_disp_o(br_disp), .call_disp_o(call_disp)
  );

  logic            a_valid, a_wide, a_scratch, a_write;
  iclass_e         a_cls;
  aluop_e          a_op;
  logic [XLEN-1:0] a_imm;

  isa_dec_arith #(.XLEN(XLEN)) u_arith (
    .minor_i(minor), .rd_i(f_rd), .mode32_i(mode32_i), .simm_i(simm),
    .valid_o(a_valid), .cls_o(a_cls), .op_o(a_op), .wide_o(a_wide),
    .scratch_o(a_scratch), .write_rd_o(a_write), .imm_o(a_imm)
  );

  logic       m_valid, m_store, m_signed, m_write, m_discard;
  logic [1:0] m_size;
  logic [4:0] m_index;

  isa_dec_mem u_mem (
    .minor_i(minor), .rd_i(f_rd), .use_imm_i(f_imm),
    .valid_o(m_valid), .store_o(m_store), .size_o(m_size), .signed_o(m_signed),
    .index_o(m_index), .write_rd_o(m_write), .discard_o(m_discard)
  );

  dec_t            d, d_q;
  logic [XLEN-1:0] imm_d, imm_q;

  always_comb begin
    d         = '0;
    d.rd      = f_rd;
    d.rs1     = f_rs1;
    d.rs2     = f_rs2;
    d.use_imm = f_imm;
    imm_d     = '0;
    unique case (major)
      2'd0: begin
        if (minor0 == 3'd4) begin
          d.cls      = (f_rd == '0) ? CL_NOP : CL_SETHI;
          d.write_rd = (f_rd != '0);
          imm_d      = upper;
        end else if (minor0 == 3'd2 && f_rd == BR_ALWAYS) begin
          d.cls = CL_BRANCH;
          imm_d = br_disp;
        end else d.illegal = 1'b1;
      end
      2'd1: begin
        d.cls      = CL_CALL;
        d.rd       = LINK_REG;
        d.write_rd = 1'b1;
        imm_d      = call_disp;
      end
      2'd2: begin
        d.cls      = a_cls;
        d.op       = a_op;
        d.wide     = a_wide;
        d.scratch  = a_scratch;
        d.write_rd = a_write;
        d.illegal  = !a_valid;
        imm_d      = a_imm;
      end
      default: begin
        d.cls       = CL_LDST;
        d.ls_store  = m_store;
        d.ls_size   = m_size;
        d.ls_signed = m_signed;
        d.ls_index  = m_index;
        d.write_rd  = m_write;
        d.discard   = m_discard;
        d.illegal   = !m_valid;
        imm_d       = simm;
      end
    endcase
    if (d.illegal) begin
      d.cls = CL_ILL;
      d.op  = OP_ADD;
      {d.wide, d.write_rd, d.scratch, d.discard} = '0;
      {d.ls_store, d.ls_size, d.ls_signed, d.ls_index} = '0;
      imm_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d_q   <= '0;
      imm_q <= '0;
    end else begin
      d_q   <= d;
      imm_q <= imm_d;
    end
  end

  assign class_o       = d_q.cls;
  assign alu_op_o      = d_q.op;
  assign rd_o          = d_q.rd;
  assign rs1_o         = d_q.rs1;
  assign rs2_o         = d_q.rs2;
  assign use_imm_o     = d_q.use_imm;
  assign imm_o         = imm_q;
  assign wide_shift_o  = d_q.wide;
  assign write_rd_o    = d_q.write_rd;
  assign scratch_dst_o = d_q.scratch;
  assign discard_o     = d_q.discard;
  assign ls_store_o    = d_q.ls_store;
  assign ls_size_o     = d_q.ls_size;
  assign ls_signed_o   = d_q.ls_signed;
  assign ls_index_o    = d_q.ls_index;
  assign illegal_o     = d_q.illegal;

  assert_illegal_quiet_R14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (class_o == CL_ILL && !write_rd_o && imm_o == '0 && ls_index_o == '0));
  assert_no_zero_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    write_rd_o |-> (rd_o != '0));
  assert_scratch_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scratch_dst_o |-> (!write_rd_o && rd_o == '0));
  assert_call_link_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (class_o == CL_CALL) |-> (rd_o == LINK_REG && write_rd_o));
  assert_discard_load_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    discard_o |-> (class_o == CL_LDST && !ls_store_o && !write_rd_o));
  assert_index_only_mem_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (class_o != CL_LDST) |-> (ls_index_o == '0 && !ls_store_o));
  assert_wide_is_shift_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wide_shift_o |-> (class_o == CL_ALU && alu_op_o >= OP_SLL && alu_op_o <= OP_SRA));
endmodule

// File: tb/sim_isa_field_decoder.sv
`timescale 1ns/1ps
module sim_isa_field_decoder;
  localparam int XLEN = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] instr = '0;
  logic m32 = 1'b0;

  logic [3:0] class_o, alu_op_o;
  logic [4:0] rd_o, rs1_o, rs2_o, ls_index_o;
  logic use_imm_o, wide_o, write_o, scratch_o, discard_o, st_o, sg_o, ill_o;
  logic [1:0] sz_o;
  logic [XLEN-1:0] imm_o;

  always #4 clk = ~clk;

  isa_field_decoder #(.XLEN(XLEN)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .instr_i(instr), .mode32_i(m32),
    .class_o(class_o), .alu_op_o(alu_op_o), .rd_o(rd_o), .rs1_o(rs1_o), .rs2_o(rs2_o),
    .use_imm_o(use_imm_o), .imm_o(imm_o), .wide_shift_o(wide_o), .write_rd_o(write_o),
    .scratch_dst_o(scratch_o), .discard_o(discard_o), .ls_store_o(st_o), .ls_size_o(sz_o),
    .ls_signed_o(sg_o), .ls_index_o(ls_index_o), .illegal_o(ill_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit have_exp = 0;

  int e_cls, e_op, e_rd, e_rs1, e_rs2, e_ui, e_wide, e_wr, e_scr, e_dis, e_st, e_sz, e_sg, e_idx, e_ill;
  logic [63:0] e_imm;
  string e_tag;

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic void ref_model(input logic [31:0] w, input logic mode);
    int r, mi, op, ok;
    logic [63:0] s13;
    r   = int'(w[29:25]);
    mi  = int'(w[24:19]);
    s13 = {{51{w[12]}}, w[12:0]};
    e_rd = r; e_rs1 = int'(w[18:14]); e_rs2 = int'(w[4:0]); e_ui = int'(w[13]);
    e_cls = 8; e_op = 0; e_imm = '0; e_wide = 0; e_wr = 0; e_scr = 0; e_dis = 0;
    e_st = 0; e_sz = 0; e_sg = 0; e_idx = 0; e_ill = 1; e_tag = "R14";
    case (w[31:30])
      2'd0: begin
        if (w[24:22] == 3'd4) begin
          e_ill = 0; e_imm = {32'b0, w[21:0], 10'b0}; e_tag = "R3";
          if (r == 0) begin e_cls = 0; e_tag = "R8"; end
          else begin e_cls = 1; e_wr = 1; end
        end else if (w[24:22] == 3'd2 && r == 8) begin
          e_ill = 0; e_cls = 2; e_imm = {{40{w[21]}}, w[21:0], 2'b00}; e_tag = "R4";
        end
      end
      2'd1: begin
        e_ill = 0; e_cls = 3; e_rd = 15; e_wr = 1; e_tag = "R5";
        e_imm = {{32{w[29]}}, w[29:0], 2'b00};
      end
      2'd2: begin
        op = -1;
        if (mi <= 4) op = mi;
        else if (mi == 20) op = 5;
        else if (mi == 37) op = 6;
        else if (mi == 38) op = 7;
        else if (mi == 39) op = 8;
        else if (mi == 60) op = 9;
        if (op >= 0) begin
          e_ill = 0; e_cls = 4; e_op = op; e_imm = s13; e_tag = "R6";
          if (op >= 6 && op <= 8) begin
            e_tag = "R7"; e_wide = int'(w[12]);
            e_imm = w[12] ? {58'b0, w[5:0]} : {59'b0, w[4:0]};
            if (w[12] && mode) e_ill = 1;
          end
          if (r == 0) begin
            e_tag = "R8";
            if (op == 5 || op == 9) e_scr = 1;
            else begin e_cls = 0; e_op = 0; e_wide = 0; end
          end else e_wr = 1;
        end else if (mi == 56) begin
          e_ill = 0; e_cls = 5; e_imm = s13; e_tag = "R9";
          if (r == 0) e_scr = 1; else e_wr = 1;
        end else if ((mi == 48 && (r == 0 || r == 6 || r == 23)) ||
                     (mi == 50 && (r == 4 || r == 6 || r == 8))) begin
          e_ill = 0; e_cls = 7; e_op = 3; e_imm = s13; e_tag = "R13";
        end
      end
      default: begin
        ok = 1;
        case (mi)
          0: e_sz = 2;
          1: e_sz = 0;
          2: e_sz = 1;
          8: begin e_sz = 2; e_sg = 1; end
          9: begin e_sz = 0; e_sg = 1; end
          10: begin e_sz = 1; e_sg = 1; end
          11: e_sz = 3;
          4: begin e_sz = 2; e_st = 1; end
          5: begin e_sz = 0; e_st = 1; end
          6: begin e_sz = 1; e_st = 1; end
          14: begin e_sz = 3; e_st = 1; end
          default: ok = 0;
        endcase
        if (ok == 1) begin
          e_ill = 0; e_cls = 6; e_imm = s13; e_tag = "R10";
          e_idx = e_ui * 16 + e_st * 8 + e_sz * 2 + e_sg;
          if (e_st == 0) begin
            if (r == 0) begin e_dis = 1; e_tag = "R12"; end else e_wr = 1;
          end
        end
      end
    endcase
    if (e_ill == 1) begin
      e_cls = 8; e_op = 0; e_imm = '0; e_wide = 0; e_wr = 0; e_scr = 0; e_dis = 0;
      e_st = 0; e_sz = 0; e_sg = 0; e_idx = 0; e_tag = "R14";
    end
  endfunction

  task automatic compare();
    chk("R1 fields", {rd_o, rs1_o, rs2_o, use_imm_o},
        {5'(e_rd), 5'(e_rs1), 5'(e_rs2), 1'(e_ui)});
    chk({e_tag, " class/op"}, {class_o, alu_op_o}, {4'(e_cls), 4'(e_op)});
    chk({e_tag, " imm"}, imm_o, e_imm);
    chk({e_tag, " ctrl"}, {wide_o, write_o, scratch_o, discard_o},
        {1'(e_wide), 1'(e_wr), 1'(e_scr), 1'(e_dis)});
    chk("R10 R11 mem", {st_o, sz_o, sg_o, ls_index_o},
        {1'(e_st), 2'(e_sz), 1'(e_sg), 5'(e_idx)});
    chk("R14 illegal", ill_o, 64'(e_ill));
  endtask

  task automatic step(input logic [31:0] w, input logic mode);
    @(negedge clk);
    if (have_exp) compare();
    instr = w;
    m32 = mode;
    ref_model(w, mode);
    have_exp = 1;
  endtask

  function automatic logic [31:0] f3(input int maj, input int rd, input int mi, input int rs1,
                                     input int i, input int lo);
    return {2'(maj), 5'(rd), 6'(mi), 5'(rs1), 1'(i), 13'(lo)};
  endfunction

  function automatic logic [31:0] f0(input int rd, input int mi, input int disp);
    return {2'b00, 5'(rd), 3'(mi), 22'(disp)};
  endfunction

  function automatic int pick(input int k);
    case (k % 13)
      0: return 0;  1: return 1;  2: return 2;  3: return 3;  4: return 4;
      5: return 20; 6: return 37; 7: return 38; 8: return 39; 9: return 56;
      10: return 60; 11: return 48; default: return 50;
    endcase
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    repeat (3) @(negedge clk);
    // R2: reset state
    chk("R2 reset", {class_o, alu_op_o, rd_o, rs1_o, rs2_o, use_imm_o, wide_o, write_o,
                     scratch_o, discard_o, st_o, sz_o, sg_o, ls_index_o, ill_o}, '0);
    chk("R2 reset imm", imm_o, '0);
    rst_n = 1'b1;
    step(f0(0, 4, 22'h3abcde), 0);             // R8 upper set to zero reg
    step(f0(5, 4, 22'h3abcde), 0);             // R3
    step(f0(8, 2, 22'h3ffffe), 0);             // R4 negative
    step(f0(8, 2, 22'h000010), 0);             // R4 positive
    step(f0(9, 2, 22'h000010), 0);             // R4 unsupported rd -> R14
    step(f0(3, 0, 0), 0);                      // R14
    step({2'b01, 30'h2000_0001}, 0);           // R5 negative
    step({2'b01, 30'h0000_0040}, 0);           // R5 positive
    step(f3(2, 0, 0, 3, 1, 13'h1fff), 0);      // R8 add to zero
    step(f3(2, 0, 20, 3, 0, 7), 0);            // R8 compare kept
    step(f3(2, 0, 60, 3, 1, 13'h1f00), 0);     // R8 save kept
    step(f3(2, 4, 2, 3, 1, 13'h1abc), 0);      // R6
    step(f3(2, 4, 37, 3, 1, 13'h103f), 1);     // R7 wide in 32-bit mode
    step(f3(2, 4, 39, 3, 1, 13'h103f), 0);     // R7 wide
    step(f3(2, 4, 38, 3, 1, 13'h003f), 1);     // R7 narrow
    step(f3(2, 0, 37, 3, 1, 13'h1005), 0);     // R8 shift to zero
    step(f3(2, 0, 56, 31, 1, 8), 0);           // R9 scratch
    step(f3(2, 7, 56, 2, 0, 1), 0);            // R9
    step(f3(2, 6, 48, 1, 1, 5), 0);            // R13
    step(f3(2, 1, 48, 1, 1, 5), 0);            // R13 bad rd
    step(f3(2, 8, 50, 1, 0, 5), 0);            // R13
    step(f3(2, 5, 50, 1, 0, 5), 0);            // R13 bad rd
    step(f3(2, 3, 5, 1, 0, 5), 0);             // R14
    for (int k = 0; k < 16; k++) step(f3(3, 9, k, 2, k % 2, 13'h1ff0 + k), 0);  // R10 R11
    step(f3(3, 0, 9, 2, 1, 4), 0);             // R12 load discard
    step(f3(3, 0, 14, 2, 0, 4), 0);            // R12 store rd zero
    for (int i = 0; i < 400; i++) begin
      w = $urandom();
      if (i % 3 != 0) w[24:19] = 6'(pick(i / 3));
      if (w[31:30] == 2'd3) w[24:19] = 6'(i % 16);
      if (i % 5 == 0) w[29:25] = '0;
      step(w, (i % 7) == 0);
    end
    @(negedge clk);
    compare();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule